// File: doc/BRIEF.md
# Coin-Operated Countdown Meter Controller

This block keeps the remaining paid time of a parking meter and presents it for a four-digit display. It runs from a 100 Hz clock and divides that clock down to a one-second tick. The stored time is decremented on each tick. Four single-cycle coin pulses add fixed amounts of time, and two single-cycle preset pulses overwrite the time with fixed values. Any sum larger than 9999 seconds is clamped to 9999.

The time is held in binary and converted to four BCD digits. A single display-enable output drives the blanking of the display. After reset the meter is idle and blinks 0000. When the paid time runs out, the meter expires and blinks 0000 again until money arrives. Below 180 seconds it shows even counts and blanks odd counts. At 180 seconds or more the display stays lit. Seven-segment encoding and digit multiplexing belong to a later stage.

Top module: `meter_ctrl`

## Requirements
- R1: A synchronous active-low reset sets the remaining time to 0 and enters the idle state. Display enable is high and stays high for the first CLK_HZ/2 cycles after release.
- R2: In the idle state the display enable alternates: high for CLK_HZ/2 cycles, then low for CLK_HZ/2 cycles. The digits read 0000 and the ticks do not change the time.
- R3: coin_pulse bits 0, 1, 2 and 3 add 60, 120, 180 and 300 seconds. The new value is visible on the outputs in the cycle after the pulse, and the meter enters the running state.
- R4: preset_pulse bit 0 loads 16 seconds and bit 1 loads 150 seconds, replacing the current value. The meter enters the running state.
- R5: While running, the time decreases by one on every CLK_HZ-th clock cycle counted from reset release. Coin and preset events do not shift this cadence.
- R6: If a coin or preset pulse coincides with a tick, the pulse is applied and that tick's decrement is dropped.
- R7: The remaining time never exceeds 9999. An addition past 9999 yields exactly 9999, and counting continues from there.
- R8: While running with 180 or more seconds left, display enable is continuously high.
- R9: While running with fewer than 180 seconds left, display enable is high when the count is even and low when it is odd.
- R10: When a decrement reaches 0, the meter enters the expired state. It shows 0000 and blinks as in R2, starting with a high phase in that same cycle, until a coin or preset pulse arrives.
- R11: digits carries the remaining time as four BCD digits: thousands in [15:12], hundreds in [11:8], tens in [7:4] and ones in [3:0]. Each digit is 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 Hz clock |
| rst_n | input | 1 | synchronous active-low reset |
| coin_pulse | input | 4 | single-cycle coin events (60/120/180/300 s) |
| preset_pulse | input | 2 | single-cycle preset loads (16/150 s) |
| digits | output | 16 | remaining time, four BCD digits |
| disp_on | output | 1 | display enable; low blanks the display |

## Verification
Each coin value is added from a different starting point, and each preset overwrites a value above the threshold. Together these separate a correct add amount from a wrong one, and a load from an add. One coin is timed onto a tick edge, then the next tick is checked, which shows the event priority and that the cadence was not restarted. A burst of largest coins drives the sum over 9999, and a further small coin is added at the ceiling, which checks the clamp. A 16-second preset is then run down to expiry. The blink is sampled at both phase boundaries in idle and in expired, and at odd and even counts below 180, which confirms which phase comes first.

// File: rtl/meter_pkg.sv
// Shared types for the countdown meter.
package meter_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_EXPIRED = 2'd2
    } meter_state_e;
endpackage

// File: rtl/meter_prescale.sv
// Free-running divider: emits a one-cycle tick every DIV clocks.
// Assumes DIV >= 2; counting starts at reset release and never restarts.
module meter_prescale #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV);

    logic [CW-1:0] cnt_q;

    // Count 0..DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1))   cnt_q <= '0;
        else                              cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/meter_blink.sv
// Half-period blink generator: on for HALF cycles, then off for HALF cycles.
// Assumes clear is held while the blink is not needed; it restarts in the on phase.
module meter_blink #(
    parameter int HALF = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic blink_on
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [HW-1:0] cnt_q;
    logic          off_q;

    // Advance the half-period counter and flip the phase at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
            off_q <= 1'b0;
        end else if (cnt_q == HW'(HALF - 1)) begin
            cnt_q <= '0;
            off_q <= ~off_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign blink_on = ~off_q;
endmodule

// File: rtl/meter_bcd.sv
// Combinational binary-to-BCD converter using the shift-and-add-3 method.
// Assumes the input value fits into ND decimal digits.
module meter_bcd #(
    parameter int BW = 14,
    parameter int ND = 4
) (
    input  logic [BW-1:0]   bin,
    output logic [ND*4-1:0] bcd
);
    // Shift in one binary bit at a time, correcting each digit before the shift.
    always_comb begin
        logic [ND*4-1:0] acc;
        acc = '0;
        for (int i = BW - 1; i >= 0; i--) begin
            for (int d = 0; d < ND; d++) begin
                if (acc[d*4 +: 4] >= 4'd5) acc[d*4 +: 4] = acc[d*4 +: 4] + 4'd3;
            end
            acc = {acc[ND*4-2:0], bin[i]};
        end
        bcd = acc;
    end
endmodule

// File: rtl/meter_ctrl.sv
// Countdown meter controller: holds remaining seconds, applies coin and preset
// events, counts down once per second and drives BCD digits plus display enable.
// Assumes at most one coin/preset pulse per cycle, each lasting a single cycle.
module meter_ctrl #(
    parameter int CLK_HZ      = 100,
    parameter int MAX_SEC     = 9999,
    parameter int LOW_SEC     = 180,
    parameter int COIN0_SEC   = 60,
    parameter int COIN1_SEC   = 120,
    parameter int COIN2_SEC   = 180,
    parameter int COIN3_SEC   = 300,
    parameter int PRESET0_SEC = 16,
    parameter int PRESET1_SEC = 150
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  coin_pulse,
    input  logic [1:0]  preset_pulse,
    output logic [15:0] digits,
    output logic        disp_on
);
    import meter_pkg::*;

    localparam int TW     = $clog2(MAX_SEC + 1);
    localparam int NCOIN  = 4;
    localparam int NDIG   = 4;
    localparam int COIN_SEC [NCOIN] = '{COIN0_SEC, COIN1_SEC, COIN2_SEC, COIN3_SEC};

    meter_state_e  state_q, state_d;
    logic [TW-1:0] remain_q, remain_d;
    logic [TW-1:0] add_val;
    logic [TW:0]   sum_w;
    logic          tick;
    logic          blink_on;

    meter_prescale #(.DIV(CLK_HZ)) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    meter_blink #(.HALF(CLK_HZ / 2)) u_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state_q == ST_RUN),
        .blink_on (blink_on)
    );

    meter_bcd #(.BW(TW), .ND(NDIG)) u_bcd (
        .bin (remain_q),
        .bcd (digits)
    );

    // Select the amount of the active coin (one-hot input assumed).
    always_comb begin
        add_val = '0;
        for (int k = 0; k < NCOIN; k++) begin
            if (coin_pulse[k]) add_val = add_val | TW'(COIN_SEC[k]);
        end
    end

    assign sum_w = {1'b0, remain_q} + {1'b0, add_val};

    // Next-state and next-time selection; events take priority over the tick.
    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        if (|preset_pulse) begin
            remain_d = preset_pulse[1] ? TW'(PRESET1_SEC) : TW'(PRESET0_SEC);
            state_d  = ST_RUN;
        end else if (|coin_pulse) begin
            remain_d = (sum_w > (TW+1)'(MAX_SEC)) ? TW'(MAX_SEC) : sum_w[TW-1:0];
            state_d  = ST_RUN;
        end else if (state_q == ST_RUN && tick) begin
            if (remain_q <= TW'(1)) begin
                remain_d = '0;
                state_d  = ST_EXPIRED;
            end else begin
                remain_d = remain_q - 1'b1;
            end
        end
    end

    // State and time registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
        end
    end

    // Display enable: steady when high, even/odd blink when low, half-second blink otherwise.
    always_comb begin
        if (state_q == ST_RUN)
            disp_on = (remain_q >= TW'(LOW_SEC)) || !remain_q[0];
        else
            disp_on = blink_on;
    end
endmodule

// File: rtl/meter_ctrl_chk.sv
// Property checker for meter_ctrl, attached by bind below.
module meter_ctrl_chk #(
    parameter int TW          = 14,
    parameter int MAX_SEC     = 9999,
    parameter int LOW_SEC     = 180,
    parameter int COIN0_SEC   = 60,
    parameter int PRESET0_SEC = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [3:0]              coin_pulse,
    input logic [1:0]              preset_pulse,
    input logic [TW-1:0]           remain_q,
    input meter_pkg::meter_state_e state_q,
    input logic [15:0]             digits,
    input logic                    disp_on
);
    import meter_pkg::*;

    logic          evt_w;
    logic [TW:0]   sum0_w;
    logic [TW-1:0] exp0_w;

    assign evt_w  = (|coin_pulse) || (|preset_pulse);
    assign sum0_w = {1'b0, remain_q} + (TW+1)'(COIN0_SEC);
    assign exp0_w = (sum0_w > (TW+1)'(MAX_SEC)) ? TW'(MAX_SEC) : sum0_w[TW-1:0];

    AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        remain_q <= TW'(MAX_SEC)); // R7

    AST_COIN_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(coin_pulse[0]) && !$past(|preset_pulse))
        |-> (remain_q == $past(exp0_w))); // R3

    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(preset_pulse[0]) && !$past(preset_pulse[1]))
        |-> (remain_q == TW'(PRESET0_SEC))); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(evt_w) && (remain_q != $past(remain_q)))
        |-> (remain_q == $past(remain_q) - 1'b1)); // R5

    AST_HIGH_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && remain_q >= TW'(LOW_SEC)) |-> disp_on); // R8

    AST_EXPIRED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXPIRED) |-> (remain_q == '0 && digits == 16'h0000)); // R10

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (digits[15:12] <= 4'd9 && digits[11:8] <= 4'd9 &&
         digits[7:4] <= 4'd9 && digits[3:0] <= 4'd9)); // R11
endmodule

bind meter_ctrl meter_ctrl_chk #(
    .TW          (TW),
    .MAX_SEC     (MAX_SEC),
    .LOW_SEC     (LOW_SEC),
    .COIN0_SEC   (COIN0_SEC),
    .PRESET0_SEC (PRESET0_SEC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .coin_pulse   (coin_pulse),
    .preset_pulse (preset_pulse),
    .remain_q     (remain_q),
    .state_q      (state_q),
    .digits       (digits),
    .disp_on      (disp_on)
);

// File: tb/tb_meter_ctrl.sv
// Self-checking bench: a vector table walked by one loop, then directed corner cases.
module tb_meter_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  coin_pulse;
    logic [1:0]  preset_pulse;
    logic [15:0] digits;
    logic        disp_on;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    meter_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .coin_pulse   (coin_pulse),
        .preset_pulse (preset_pulse),
        .digits       (digits),
        .disp_on      (disp_on)
    );

    // Vector: {req[3:0], evt[3:0], wait[11:0], digits[15:0], on}
    // evt 0 none, 1..4 coin bit 0..3, 5..6 preset bit 0..1; the pulse consumes one cycle.
    localparam int NVEC = 15;
    localparam logic [36:0] VEC [NVEC] = '{
        {4'd2,  4'd0, 12'd10,  16'h0000, 1'b1},  // R2 idle, first half
        {4'd2,  4'd0, 12'd40,  16'h0000, 1'b0},  // R2 idle, second half
        {4'd2,  4'd0, 12'd50,  16'h0000, 1'b1},  // R2 idle, no decrement on tick
        {4'd3,  4'd4, 12'd0,   16'h0300, 1'b1},  // R3 coin 300
        {4'd5,  4'd0, 12'd99,  16'h0299, 1'b1},  // R5 one-second step
        {4'd3,  4'd2, 12'd0,   16'h0419, 1'b1},  // R3 coin 120
        {4'd5,  4'd0, 12'd99,  16'h0418, 1'b1},  // R5 cadence kept
        {4'd4,  4'd6, 12'd0,   16'h0150, 1'b1},  // R4 preset 150
        {4'd9,  4'd0, 12'd99,  16'h0149, 1'b0},  // R9 odd blanked
        {4'd9,  4'd0, 12'd100, 16'h0148, 1'b1},  // R9 even shown
        {4'd4,  4'd5, 12'd0,   16'h0016, 1'b1},  // R4 preset 16
        {4'd3,  4'd1, 12'd0,   16'h0076, 1'b1},  // R3 coin 60
        {4'd5,  4'd0, 12'd97,  16'h0076, 1'b1},  // R5 just before tick
        {4'd6,  4'd3, 12'd0,   16'h0256, 1'b1},  // R6 coin 180 on tick edge
        {4'd8,  4'd0, 12'd100, 16'h0255, 1'b1}   // R8 steady, R5 cadence unchanged
    };

    task automatic check(input int req, input logic [15:0] exp_d, input logic exp_on);
        n_chk++;
        if (digits !== exp_d || disp_on !== exp_on) begin
            n_fail++;
            $display("FAIL R%0d digits=%h/on=%b expected %h/%b", req, digits, disp_on, exp_d, exp_on);
        end
    endtask

    task automatic pulse(input logic [3:0] evt);
        if (evt >= 4'd1 && evt <= 4'd4) coin_pulse[evt - 4'd1] = 1'b1;
        if (evt >= 4'd5 && evt <= 4'd6) preset_pulse[evt - 4'd5] = 1'b1;
        @(negedge clk);
        coin_pulse   = '0;
        preset_pulse = '0;
    endtask

    initial begin
        rst_n        = 1'b0;
        coin_pulse   = '0;
        preset_pulse = '0;
        repeat (3) @(negedge clk);
        check(1, 16'h0000, 1'b1);                // R1 held in reset
        rst_n = 1'b1;                            // cycle position 0

        for (int i = 0; i < NVEC; i++) begin
            logic [36:0] v;
            v = VEC[i];
            if (v[32:29] != 4'd0) pulse(v[32:29]);
            repeat (int'(v[28:17])) @(negedge clk);
            check(int'(v[36:33]), v[16:1], v[0]);
        end

        // R7: 33 coins of 300 from 255 overshoot 9999 (position 700 -> 766)
        for (int k = 0; k < 33; k++) begin
            pulse(4'd4);
            @(negedge clk);
        end
        check(7, 16'h9999, 1'b1);
        repeat (34) @(negedge clk);              // position 800
        check(7, 16'h9998, 1'b1);                // R7 counts on from the ceiling
        pulse(4'd1);                             // position 801
        check(7, 16'h9999, 1'b1);                // R7 small coin clamps again
        repeat (9) @(negedge clk);
        pulse(4'd5);                             // position 811
        check(4, 16'h0016, 1'b1);                // R4 overwrite from the ceiling
        repeat (1588) @(negedge clk);            // position 2399
        check(9, 16'h0001, 1'b0);                // R9 last odd second
        @(negedge clk);                          // position 2400
        check(10, 16'h0000, 1'b1);               // R10 expiry starts in on phase
        repeat (49) @(negedge clk);
        check(10, 16'h0000, 1'b1);               // R10 last on cycle
        @(negedge clk);
        check(10, 16'h0000, 1'b0);               // R10 off phase
        repeat (50) @(negedge clk);              // position 2500
        check(10, 16'h0000, 1'b1);               // R10 stays at zero
        repeat (10) @(negedge clk);
        pulse(4'd1);                             // position 2511
        check(3, 16'h0060, 1'b1);                // R3 coin leaves expired state
        repeat (89) @(negedge clk);              // position 2600
        check(9, 16'h0059, 1'b0);                // R9

        rst_n = 1'b0;
        @(negedge clk);
        check(1, 16'h0000, 1'b1);                // R1 reset mid-run
        rst_n = 1'b1;
        repeat (49) @(negedge clk);
        check(1, 16'h0000, 1'b1);                // R1 first half after release
        @(negedge clk);
        check(1, 16'h0000, 1'b0);                // R1 then off

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule